// File: doc/BRIEF.md
# Byte SPI Port with Enable-Line Silencing

This block is a byte-wide SPI shift port. It works either as the clock-driving end of the link or as the clocked end, selected by a mode input. As the driving end it divides the system clock down to a serial clock, shifts a queued transmit byte out MSB first and collects a receive byte at the same time. As the clocked end it follows an external serial clock, brought into the system clock domain through synchronizers.

An active-low enable line, `ste_n`, can silence the port at any moment. Pulling it low drops the output enables of the serial data pin, and of the clock pin when driving, in the same instant, through a purely combinational path. The transfer state reacts through a two-stage synchronizer, and the reaction depends on the mode. A driving port throws its frame away and returns to idle. A clocked port freezes with its bit position intact and carries on from that point once the line is released. Neither case raises any flag.

Software sees a transmit byte with a load strobe and a one-entry holding buffer, a receive byte with a one-cycle valid pulse, a busy level, and a synchronous clear input.

Top module: `spi_gated_port`

## Requirements
- R1: With `is_master`=1, a frame starts one cycle after the port is idle with a byte in the buffer. `sclk_o` idles low and toggles every `clk_div`+1 system cycles, so one serial period is 2×(`clk_div`+1) cycles. Each frame has 8 rising edges. `so_o` presents bit 7 first and moves to the next lower bit on each falling edge. `busy` is high for exactly 16×(`clk_div`+1) cycles per frame.
- R2: `si_i` is sampled on every rising serial edge, whatever drives it. After the eighth sample, `rx_valid` is high for exactly one cycle and `rx_data` holds the eight samples, with the first one in bit 7. A line held at 1 yields 0xFF.
- R3: A byte loaded while a frame runs is kept and sent as the next frame. A load that lands in the same cycle the buffer is emptied into a starting frame is kept for the frame after that.
- R4: While `ste_n` is 0, `so_oe` is 0, and `sclk_oe` is 0. This takes effect in the same instant `ste_n` falls, with no clock edge needed.
- R5: In driving mode, once `ste_n` has been low for three clock edges, the running frame is gone: `busy` is 0, `sclk_o` is low, and no `rx_valid` is produced for that frame. No new frame starts while `ste_n` stays low. A buffered byte starts once the line is released.
- R6: With `is_master`=0, `si_i` is sampled on rising `sclk_i` edges and `so_o` advances on falling edges. After eight rising edges, `rx_valid` pulses with the byte. `busy` is high from the first rising edge until the eighth.
- R7: In clocked mode, `sclk_i` edges that occur while `ste_n` is low are ignored. The bit position and both shift registers are held, so the frame finishes correctly after release, even if it was frozen between a rising and a falling edge.
- R8: In clocked mode, if no byte was loaded, the port shifts out ones, so the far end reads 0xFF.
- R9: A one-cycle `soft_rst` clears the bit position, the shift registers and the pending buffer. `busy` and `rx_valid` are 0 in the next cycle, and a frame clocked in afterwards sends 0xFF.
- R10: During reset, `busy`, `rx_valid` and `sclk_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_master | input | 1 | 1 = port drives the serial clock, 0 = port follows it |
| clk_div | input | 8 | Serial half-period minus one, in system cycles |
| soft_rst | input | 1 | Synchronous clear of transfer state and buffer |
| tx_data | input | 8 | Byte to transmit |
| tx_load | input | 1 | Strobe that writes `tx_data` into the buffer |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse when `rx_data` is new |
| busy | output | 1 | Frame in progress |
| ste_n | input | 1 | Active-low silencing line |
| sclk_i | input | 1 | Serial clock from the far end (clocked mode) |
| sclk_o | output | 1 | Serial clock generated here (driving mode) |
| sclk_oe | output | 1 | Output enable for `sclk_o` |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so_o` |

## Verification
Two things can happen in the same cycle. A transmit load can arrive in the cycle the holding buffer is emptied into a new frame. The silencing line can also fall in the cycle a frame would have started. The bench provokes the first case by watching `busy` fall and asserting `tx_load` at that same sampling point, which lands the write on the start edge. It provokes the second by loading a byte while `ste_n` is held low. A behavioural model clocked alongside the design is compared on every cycle. It judges both cases by the exact serial clock pattern, the `busy` level and the sequence of received bytes: the colliding write has to appear as its own frame, and no frame may start before release.

// File: rtl/spi_gated_pkg.sv
package spi_gated_pkg;
  localparam int unsigned FRAME_W = 8;
  localparam int unsigned DIV_W   = 8;
endpackage

// File: rtl/spi_rst_sync.sv
// Asynchronous assert, synchronous release of the internal reset.
module spi_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] chain_q, chain_d;

  always_comb chain_d = {chain_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[1];
endmodule

// File: rtl/spi_sync2.sv
// Two-stage level synchronizer with a per-bit reset value.
module spi_sync2 #(
  parameter int unsigned    N       = 1,
  parameter logic [N-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] meta_q, meta_d, sync_q, sync_d;

  always_comb begin
    meta_d = d;
    sync_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/spi_edge_det.sv
// Rising/falling detector on an already synchronized level.
module spi_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev_q, prev_d;

  always_comb prev_d = lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/spi_clk_div.sv
// Half-period tick generator; counter parks at zero while not running.
module spi_clk_div #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [DW-1:0] cnt_q, cnt_d;
  logic          at_end;

  assign at_end = (cnt_q == div);
  assign tick   = run & at_end;

  always_comb begin
    if (!run)        cnt_d = '0;
    else if (at_end) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_shift_core.sv
// Frame sequencing for both modes: buffer, shifters, bit position.
module spi_shift_core #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic         is_master,
  input  logic         ste_ok,
  input  logic         tick,
  input  logic         ext_rise,
  input  logic         ext_fall,
  input  logic         si,
  input  logic [W-1:0] tx_data,
  input  logic         tx_load,
  output logic         run,
  output logic         sclk_q,
  output logic         so_bit,
  output logic         busy,
  output logic [W-1:0] rx_data,
  output logic         rx_valid
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          busy_q, busy_d;
  logic          sclk_d;
  logic [CW-1:0] bit_q, bit_d;
  logic [W-1:0]  txsh_q, txsh_d;
  logic [W-1:0]  rxsh_q, rxsh_d;
  logic [W-1:0]  rxd_q, rxd_d;
  logic          rxv_q, rxv_d;
  logic [W-1:0]  buf_q, buf_d;
  logic          full_q, full_d;

  always_comb begin
    busy_d = busy_q;
    sclk_d = sclk_q;
    bit_d  = bit_q;
    txsh_d = txsh_q;
    rxsh_d = rxsh_q;
    rxd_d  = rxd_q;
    rxv_d  = 1'b0;
    buf_d  = buf_q;
    full_d = full_q;
    if (soft_rst) begin
      busy_d = 1'b0;
      sclk_d = 1'b0;
      bit_d  = '0;
      txsh_d = '1;
      rxsh_d = '0;
      full_d = 1'b0;
    end else begin
      if (is_master) begin
        if (!ste_ok) begin
          // silenced: drop the frame, nothing reported
          busy_d = 1'b0;
          sclk_d = 1'b0;
          bit_d  = '0;
        end else if (busy_q) begin
          if (tick) begin
            if (!sclk_q) begin
              sclk_d = 1'b1;
              rxsh_d = {rxsh_q[W-2:0], si};
              if (bit_q == LAST) begin
                rxd_d = rxsh_d;
                rxv_d = 1'b1;
              end
            end else begin
              sclk_d = 1'b0;
              txsh_d = {txsh_q[W-2:0], 1'b1};
              if (bit_q == LAST) begin
                busy_d = 1'b0;
                bit_d  = '0;
              end else begin
                bit_d = bit_q + 1'b1;
              end
            end
          end
        end else if (full_q) begin
          busy_d = 1'b1;
          sclk_d = 1'b0;
          bit_d  = '0;
          txsh_d = buf_q;
          full_d = 1'b0;
        end
      end else begin
        busy_d = 1'b0;
        sclk_d = 1'b0;
        if (ste_ok) begin
          if ((bit_q == '0) && full_q) begin
            txsh_d = buf_q;
            full_d = 1'b0;
          end
          if (ext_rise) begin
            rxsh_d = {rxsh_q[W-2:0], si};
            if (bit_q == LAST) begin
              rxd_d  = rxsh_d;
              rxv_d  = 1'b1;
              bit_d  = '0;
              txsh_d = '1;
            end else begin
              bit_d = bit_q + 1'b1;
            end
          end else if (ext_fall && (bit_q != '0)) begin
            txsh_d = {txsh_q[W-2:0], 1'b1};
          end
        end
      end
      if (tx_load) begin
        buf_d  = tx_data;
        full_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      bit_q  <= '0;
      txsh_q <= '1;
      rxsh_q <= '0;
      rxd_q  <= '0;
      rxv_q  <= 1'b0;
      buf_q  <= '0;
      full_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      bit_q  <= bit_d;
      txsh_q <= txsh_d;
      rxsh_q <= rxsh_d;
      rxd_q  <= rxd_d;
      rxv_q  <= rxv_d;
      buf_q  <= buf_d;
      full_q <= full_d;
    end
  end

  assign run      = busy_q & is_master;
  assign so_bit   = txsh_q[W-1];
  assign busy     = is_master ? busy_q : (bit_q != '0);
  assign rx_data  = rxd_q;
  assign rx_valid = rxv_q;
endmodule

// File: rtl/spi_gated_port.sv
module spi_gated_port
  import spi_gated_pkg::*;
#(
  parameter int unsigned W  = FRAME_W,
  parameter int unsigned DW = DIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_master,
  input  logic [DW-1:0] clk_div,
  input  logic          soft_rst,
  input  logic [W-1:0]  tx_data,
  input  logic          tx_load,
  output logic [W-1:0]  rx_data,
  output logic          rx_valid,
  output logic          busy,
  input  logic          ste_n,
  input  logic          sclk_i,
  output logic          sclk_o,
  output logic          sclk_oe,
  input  logic          si_i,
  output logic          so_o,
  output logic          so_oe
);
  logic       rst_n_s;
  logic [1:0] sync_q;
  logic       ext_rise, ext_fall;
  logic       run, tick, sclk_q, so_bit;

  spi_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  // bit 1: silencing line (idles released), bit 0: external clock
  spi_sync2 #(.N(2), .RST_VAL(2'b10)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d     ({ste_n, sclk_i}),
    .q     (sync_q)
  );

  spi_edge_det u_edge (
    .clk   (clk),
    .rst_n (rst_n_s),
    .lvl   (sync_q[0]),
    .rise  (ext_rise),
    .fall  (ext_fall)
  );

  spi_clk_div #(.DW(DW)) u_div (
    .clk   (clk),
    .rst_n (rst_n_s),
    .run   (run),
    .div   (clk_div),
    .tick  (tick)
  );

  spi_shift_core #(.W(W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .soft_rst  (soft_rst),
    .is_master (is_master),
    .ste_ok    (sync_q[1]),
    .tick      (tick),
    .ext_rise  (ext_rise),
    .ext_fall  (ext_fall),
    .si        (si_i),
    .tx_data   (tx_data),
    .tx_load   (tx_load),
    .run       (run),
    .sclk_q    (sclk_q),
    .so_bit    (so_bit),
    .busy      (busy),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid)
  );

  // Driver enables bypass the synchronizer so silencing is immediate.
  assign sclk_oe = is_master & ste_n;
  assign so_oe   = ste_n;
  assign sclk_o  = sclk_q & is_master;
  assign so_o    = so_bit;
endmodule

// File: rtl/spi_gated_port_chk.sv
module spi_gated_port_chk (
  input logic clk,
  input logic rst_n,
  input logic is_master,
  input logic soft_rst,
  input logic ste_n,
  input logic so_oe,
  input logic sclk_oe,
  input logic sclk_o,
  input logic busy,
  input logic rx_valid
);
  // R4
  ste_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ste_n |-> (!so_oe && !sclk_oe));

  // R2
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R2
  rx_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && rx_valid) |-> (sclk_o && busy));

  // R1
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && !busy) |-> !sclk_o);

  // R5
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && !ste_n && $past(!ste_n) && $past(!ste_n, 2) && $past(!ste_n, 3)) |-> !busy);

  // R9
  soft_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!busy && !rx_valid));
endmodule

bind spi_gated_port spi_gated_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .is_master (is_master),
  .soft_rst  (soft_rst),
  .ste_n     (ste_n),
  .so_oe     (so_oe),
  .sclk_oe   (sclk_oe),
  .sclk_o    (sclk_o),
  .busy      (busy),
  .rx_valid  (rx_valid)
);

// File: tb/spi_gated_port_bench.sv
module spi_gated_port_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       is_master = 1'b1;
  logic [7:0] clk_div = 8'd3;
  logic       soft_rst = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_load = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, busy;
  logic       ste_n = 1'b1;
  logic       sclk_i = 1'b0;
  logic       sclk_o, sclk_oe;
  logic       si_i = 1'b0;
  logic       so_o, so_oe;

  spi_gated_port u_spi_gated_port (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .clk_div(clk_div),
    .soft_rst(soft_rst), .tx_data(tx_data), .tx_load(tx_load),
    .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy), .ste_n(ste_n),
    .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe), .si_i(si_i),
    .so_o(so_o), .so_oe(so_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // stimulus controls for the serial input
  bit   master_phase = 1;
  bit   cmp_en = 0;
  bit   lb_mode = 1;
  logic lb_inv = 1'b0;
  logic cst_bit = 1'b0;
  logic slv_si = 1'b0;

  // behavioural model of the driving mode
  logic       m_s1 = 1'b1, m_s2 = 1'b1;
  logic       m_busy = 0, m_sclk = 0, m_rxv = 0, m_full = 0;
  int         m_cnt = 0, m_bit = 0;
  logic [7:0] m_txsh = 8'hFF, m_rxsh = 0, m_rxd = 0, m_buf = 0;

  always @(posedge clk) begin
    logic msi;
    msi = lb_mode ? (m_txsh[7] ^ lb_inv) : cst_bit;
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_busy = 0; m_sclk = 0; m_rxv = 0; m_full = 0;
      m_cnt = 0; m_bit = 0; m_txsh = 8'hFF; m_rxsh = 0; m_rxd = 0; m_buf = 0;
    end else begin
      m_rxv = 0;
      if (soft_rst) begin
        m_busy = 0; m_sclk = 0; m_bit = 0; m_cnt = 0; m_txsh = 8'hFF; m_full = 0;
      end else begin
        if (!m_s2) begin
          m_busy = 0; m_sclk = 0; m_bit = 0; m_cnt = 0;
        end else if (m_busy) begin
          if (m_cnt == int'(clk_div)) begin
            m_cnt = 0;
            if (!m_sclk) begin
              m_sclk = 1;
              m_rxsh = {m_rxsh[6:0], msi};
              if (m_bit == 7) begin m_rxd = m_rxsh; m_rxv = 1; end
            end else begin
              m_sclk = 0;
              m_txsh = {m_txsh[6:0], 1'b1};
              if (m_bit == 7) begin m_busy = 0; m_bit = 0; end
              else m_bit++;
            end
          end else m_cnt++;
        end else if (m_full) begin
          m_busy = 1; m_sclk = 0; m_bit = 0; m_cnt = 0; m_txsh = m_buf; m_full = 0;
        end
        if (tx_load) begin m_buf = tx_data; m_full = 1; end
      end
      m_s2 = m_s1;
      m_s1 = ste_n;
    end
  end

  // serial input driven away from the active edge
  always @(negedge clk)
    si_i = master_phase ? (lb_mode ? (m_txsh[7] ^ lb_inv) : cst_bit) : slv_si;

  // received-byte monitor and per-cycle comparison
  logic [7:0] rx_q[$];
  int         rx_cnt = 0;
  logic [7:0] rx_last = 0;

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      rx_cnt++;
      rx_last = rx_data;
      if (master_phase) rx_q.push_back(rx_data);
    end
    if (cmp_en) begin
      check(sclk_o == m_sclk, "R1 sclk_o", sclk_o, m_sclk);
      check(so_o == m_txsh[7], "R1 so_o", so_o, m_txsh[7]);
      check(busy == m_busy, "R1 busy", busy, m_busy);
      check(rx_valid == m_rxv, "R2 rx_valid", rx_valid, m_rxv);
      if (m_rxv) check(rx_data == m_rxd, "R2 rx_data", rx_data, m_rxd);
    end
  end

  task automatic pulse_load(input logic [7:0] b);
    tx_data = b;
    tx_load = 1;
    @(negedge clk);
    tx_load = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // far-end clocking for the clocked mode: bits [from..to] of a frame
  task automatic sbits(input logic [7:0] mo, input int from, input int upto,
                       inout logic [7:0] mi);
    for (int i = from; i <= upto; i++) begin
      slv_si = mo[7-i];
      wait_cyc(8);
      mi[7-i] = so_o;
      sclk_i = 1;
      wait_cyc(8);
      sclk_i = 0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0] mi;
    int c0;
    wait_cyc(3);
    // R10 reset state
    check(busy == 0, "R10 busy", busy, 0);
    check(rx_valid == 0, "R10 rx_valid", rx_valid, 0);
    check(sclk_o == 0, "R10 sclk_o", sclk_o, 0);
    rst_n = 1;
    wait_cyc(4);
    cmp_en = 1;

    // R3: buffered byte during a frame, then a load colliding with buffer consumption
    pulse_load(8'hA5);
    while (!busy) @(negedge clk);
    pulse_load(8'h3C);
    do @(negedge clk); while (busy);
    tx_data = 8'hC7;
    tx_load = 1;
    @(negedge clk);
    tx_load = 0;
    wait_cyc(160);
    check(rx_q.size() == 3, "R3 frame count", rx_q.size(), 3);
    if (rx_q.size() == 3) begin
      check(rx_q[0] == 8'hA5, "R3 byte0", rx_q[0], 8'hA5);
      check(rx_q[1] == 8'h3C, "R3 byte1", rx_q[1], 8'h3C);
      check(rx_q[2] == 8'hC7, "R3 byte2", rx_q[2], 8'hC7);
    end

    // R4/R5: silence mid-frame
    pulse_load(8'h96);
    wait_cyc(30);
    ste_n = 0;
    #1;
    check(so_oe == 0, "R4 so_oe master", so_oe, 0);
    check(sclk_oe == 0, "R4 sclk_oe master", sclk_oe, 0);
    wait_cyc(8);
    check(busy == 0, "R5 busy after abort", busy, 0);
    check(sclk_o == 0, "R5 sclk_o after abort", sclk_o, 0);
    ste_n = 1;
    wait_cyc(10);
    check(rx_q.size() == 3, "R5 no rx for aborted frame", rx_q.size(), 3);

    // R5: no start while silenced, start after release
    ste_n = 0;
    wait_cyc(4);
    pulse_load(8'hE1);
    wait_cyc(10);
    check(busy == 0, "R5 held while silenced", busy, 0);
    ste_n = 1;
    wait_cyc(90);
    check(rx_q.size() == 4 && rx_q[3] == 8'hE1, "R5 resumed frame", rx_q[rx_q.size()-1], 8'hE1);

    // R2: constant-one input gives 0xFF
    lb_mode = 0; cst_bit = 1;
    pulse_load(8'h00);
    wait_cyc(90);
    check(rx_q.size() == 5 && rx_q[4] == 8'hFF, "R2 ones line", rx_q[rx_q.size()-1], 8'hFF);

    // R1/R2: fastest divider, inverted loopback
    lb_mode = 1; lb_inv = 1; clk_div = 8'd0;
    pulse_load(8'h96);
    wait_cyc(40);
    check(rx_q.size() == 6 && rx_q[5] == 8'h69, "R2 inverted", rx_q[rx_q.size()-1], 8'h69);
    lb_inv = 0;

    // clocked mode
    cmp_en = 0;
    master_phase = 0;
    is_master = 0;
    soft_rst = 1;
    @(negedge clk);
    soft_rst = 0;
    wait_cyc(4);

    // R6: normal clocked frame
    pulse_load(8'h5A);
    wait_cyc(4);
    c0 = rx_cnt; mi = 0;
    sbits(8'hC3, 0, 7, mi);
    wait_cyc(8);
    check(rx_cnt == c0 + 1, "R6 one rx pulse", rx_cnt, c0 + 1);
    check(rx_last == 8'hC3, "R6 rx byte", rx_last, 8'hC3);
    check(mi == 8'h5A, "R6 so_o byte", mi, 8'h5A);
    check(busy == 0, "R6 idle after frame", busy, 0);

    // R8: nothing loaded
    mi = 0;
    sbits(8'h81, 0, 7, mi);
    wait_cyc(8);
    check(mi == 8'hFF, "R8 empty sends ones", mi, 8'hFF);
    check(rx_last == 8'h81, "R8 rx byte", rx_last, 8'h81);

    // R7: freeze between rising and falling edge, then resume
    pulse_load(8'h3D);
    wait_cyc(4);
    c0 = rx_cnt; mi = 0;
    sbits(8'hE7, 0, 2, mi);
    slv_si = 1'b0;          // bit 3 of 0xE7
    wait_cyc(8);
    mi[4] = so_o;
    sclk_i = 1;
    wait_cyc(8);
    ste_n = 0;
    #1;
    check(so_oe == 0, "R4 so_oe slave", so_oe, 0);
    wait_cyc(4);
    for (int k = 0; k < 2; k++) begin
      slv_si = ~slv_si;
      sclk_i = 0; wait_cyc(8);
      sclk_i = 1; wait_cyc(8);
    end
    check(busy == 1, "R7 position held", busy, 1);
    check(rx_cnt == c0, "R7 frozen edges ignored", rx_cnt, c0);
    ste_n = 1;
    wait_cyc(8);
    sclk_i = 0;
    sbits(8'hE7, 4, 7, mi);
    wait_cyc(8);
    check(rx_cnt == c0 + 1, "R7 one rx pulse", rx_cnt, c0 + 1);
    check(rx_last == 8'hE7, "R7 rx after resume", rx_last, 8'hE7);
    check(mi == 8'h3D, "R7 so_o after resume", mi, 8'h3D);

    // R9: software clear drops a half-shifted frame and the buffer
    pulse_load(8'h77);
    wait_cyc(4);
    mi = 0;
    sbits(8'hF0, 0, 3, mi);
    wait_cyc(6);
    check(busy == 1, "R9 mid-frame busy", busy, 1);
    pulse_load(8'h11);
    soft_rst = 1;
    @(negedge clk);
    soft_rst = 0;
    check(busy == 0, "R9 busy cleared", busy, 0);
    mi = 0;
    sbits(8'h2B, 0, 7, mi);
    wait_cyc(8);
    check(rx_last == 8'h2B, "R9 clean frame", rx_last, 8'h2B);
    check(mi == 8'hFF, "R9 buffer dropped", mi, 8'hFF);

    finish_run();
  end
endmodule